// File: doc/BRIEF.md
# Deferred-Fault Poison Tracker

This block tracks faults raised by instructions that a compiler has hoisted above a branch. Each architectural register has one poison flag. A speculative instruction that takes a terminating fault does not trap. Instead, its destination register is marked poisoned. The trap happens later, and only if a non-speculative instruction reads that poisoned register. So a hoisted load whose result is never used costs nothing.

Each cycle, at most one instruction retires into the block. The retire record holds:
- a speculative flag;
- up to two source register indices and one destination register index, each with its own enable;
- a fault indication, with a class of resumable or terminating.

From this record the block produces three results, all registered and all visible in the cycle after retirement:
- the register-write control (write enable, index, and the poison value written);
- the updated poison flags;
- an exception request. It carries a cause code and the register index that identifies the fault.

Top module: `poison_tracker`

## Requirements
- R1: A synchronous reset clears every poison flag and drives the write and exception outputs low.
- R2: A speculative instruction with a terminating fault (`ret_fault`=1, `ret_fault_term`=1) raises no exception. If its destination is enabled, it writes that destination with `wr_poison_o`=1, and the destination's flag becomes set.
- R3: A non-speculative instruction that reads an enabled source with a set flag raises an exception with cause 3 (poison consumed). It reports that source's index on `exc_reg_o` and writes nothing. When both sources are poisoned, source A is reported.
- R4: A resumable fault (`ret_fault`=1, `ret_fault_term`=0) raises cause 1 with the destination index, whether or not the instruction is speculative. It writes nothing and leaves all poison flags unchanged.
- R5: A speculative instruction that reads a poisoned enabled source raises nothing and writes its destination with `wr_poison_o`=1.
- R6: A write with no poison clears the destination's flag. This applies to speculative and non-speculative instructions alike.
- R7: A non-speculative instruction with its own terminating fault raises cause 2 with the destination index and writes nothing.
- R8: The write and exception outputs appear in the cycle after retirement. They hold for that one cycle only, unless another instruction retires. Cause 0 means no exception.
- R9: For a non-speculative instruction, consuming poison takes priority over its own resumable fault.
- R10: A source whose enable is low never triggers poison handling, even if its index names a poisoned register.
- R11: A cycle with `ret_valid` low changes no flag and produces no write and no exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ret_valid | input | 1 | An instruction retires this cycle |
| ret_spec | input | 1 | Retiring instruction is speculative |
| ret_src_a_en | input | 1 | Source A is read |
| ret_src_a | input | IDX_W (5) | Source A register index |
| ret_src_b_en | input | 1 | Source B is read |
| ret_src_b | input | IDX_W (5) | Source B register index |
| ret_dst_en | input | 1 | Instruction writes a destination |
| ret_dst | input | IDX_W (5) | Destination register index |
| ret_fault | input | 1 | Instruction incurred a fault |
| ret_fault_term | input | 1 | Fault class: 1 terminating, 0 resumable |
| wr_en_o | output | 1 | Register write permitted |
| wr_idx_o | output | IDX_W (5) | Register being written |
| wr_poison_o | output | 1 | Poison value given to the written register |
| exc_valid_o | output | 1 | Exception request |
| exc_cause_o | output | 2 | 0 none, 1 resumable, 2 terminating, 3 poison consumed |
| exc_reg_o | output | IDX_W (5) | Faulting register index |

## Verification
Every result is due exactly one clock edge after the retire cycle. This covers the write control, the exception request, and the poison flags, which a following instruction can already read.

The bench drives one retire record on a falling edge and removes it just after the next rising edge. It then samples all outputs in that same cycle, so each check sees the results of exactly one instruction.

The poison flags are observed only through the ports. A later non-speculative probe reads the register and must (or must not) raise cause 3. One further idle cycle is sampled to confirm that the exception output has dropped.

// File: rtl/poison_pkg.sv
package poison_pkg;

    localparam int DEFAULT_REGS = 32;

    typedef enum logic [1:0] {
        CAUSE_NONE   = 2'd0,
        CAUSE_RESUME = 2'd1,
        CAUSE_TERM   = 2'd2,
        CAUSE_POISON = 2'd3
    } cause_e;

    typedef struct packed {
        logic   wr_en;
        logic   wr_poison;
        logic   raise;
        cause_e cause;
        logic   use_src_b;
    } verdict_t;

    // Decide one retiring instruction given the flags of its sources.
    function automatic verdict_t judge(
        input logic valid,
        input logic spec,
        input logic a_hit,
        input logic b_hit,
        input logic dst_en,
        input logic fault,
        input logic term
    );
        verdict_t v;
        logic     tainted;
        v       = '{wr_en: 1'b0, wr_poison: 1'b0, raise: 1'b0,
                    cause: CAUSE_NONE, use_src_b: 1'b0};
        tainted = a_hit | b_hit;
        if (valid) begin
            if (!spec && tainted) begin
                v.raise     = 1'b1;
                v.cause     = CAUSE_POISON;
                v.use_src_b = !a_hit;
            end else if (fault && !term) begin
                v.raise = 1'b1;
                v.cause = CAUSE_RESUME;
            end else if (fault && term && !spec) begin
                v.raise = 1'b1;
                v.cause = CAUSE_TERM;
            end else begin
                v.wr_en     = dst_en;
                v.wr_poison = spec & ((fault & term) | tainted);
            end
        end
        return v;
    endfunction

endpackage

// File: rtl/poison_file.sv
module poison_file #(
    parameter int NUM_REGS = 32,
    parameter int IDX_W    = $clog2(NUM_REGS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [IDX_W-1:0]    rd_a_idx,
    input  logic [IDX_W-1:0]    rd_b_idx,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic                wr_val,
    output logic                rd_a,
    output logic                rd_b,
    output logic [NUM_REGS-1:0] flags
);

    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_flag
            always_ff @(posedge clk) begin
                if (rst) begin
                    flags[g] <= 1'b0;
                end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                    flags[g] <= wr_val;
                end
            end
        end
    endgenerate

    assign rd_a = flags[rd_a_idx];
    assign rd_b = flags[rd_b_idx];

endmodule

// File: rtl/poison_decide.sv
module poison_decide
    import poison_pkg::*;
(
    input  logic     valid,
    input  logic     spec,
    input  logic     a_en,
    input  logic     a_flag,
    input  logic     b_en,
    input  logic     b_flag,
    input  logic     dst_en,
    input  logic     fault,
    input  logic     term,
    output verdict_t verdict
);

    logic a_hit;
    logic b_hit;

    assign a_hit   = a_en & a_flag;
    assign b_hit   = b_en & b_flag;
    assign verdict = judge(valid, spec, a_hit, b_hit, dst_en, fault, term);

endmodule

// File: rtl/poison_tracker.sv
module poison_tracker
    import poison_pkg::*;
#(
    parameter int NUM_REGS = poison_pkg::DEFAULT_REGS,
    parameter int IDX_W    = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ret_valid,
    input  logic             ret_spec,
    input  logic             ret_src_a_en,
    input  logic [IDX_W-1:0] ret_src_a,
    input  logic             ret_src_b_en,
    input  logic [IDX_W-1:0] ret_src_b,
    input  logic             ret_dst_en,
    input  logic [IDX_W-1:0] ret_dst,
    input  logic             ret_fault,
    input  logic             ret_fault_term,
    output logic             wr_en_o,
    output logic [IDX_W-1:0] wr_idx_o,
    output logic             wr_poison_o,
    output logic             exc_valid_o,
    output logic [1:0]       exc_cause_o,
    output logic [IDX_W-1:0] exc_reg_o
);

    logic                flag_a;
    logic                flag_b;
    logic [NUM_REGS-1:0] poison_vec;
    verdict_t            verdict;
    logic [IDX_W-1:0]    fault_idx;

    poison_decide u_decide (
        .valid   (ret_valid),
        .spec    (ret_spec),
        .a_en    (ret_src_a_en),
        .a_flag  (flag_a),
        .b_en    (ret_src_b_en),
        .b_flag  (flag_b),
        .dst_en  (ret_dst_en),
        .fault   (ret_fault),
        .term    (ret_fault_term),
        .verdict (verdict)
    );

    poison_file #(
        .NUM_REGS (NUM_REGS),
        .IDX_W    (IDX_W)
    ) u_file (
        .clk      (clk),
        .rst      (rst),
        .rd_a_idx (ret_src_a),
        .rd_b_idx (ret_src_b),
        .wr_en    (verdict.wr_en),
        .wr_idx   (ret_dst),
        .wr_val   (verdict.wr_poison),
        .rd_a     (flag_a),
        .rd_b     (flag_b),
        .flags    (poison_vec)
    );

    always_comb begin
        if (verdict.cause == CAUSE_POISON) begin
            fault_idx = verdict.use_src_b ? ret_src_b : ret_src_a;
        end else begin
            fault_idx = ret_dst;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_en_o     <= 1'b0;
            wr_idx_o    <= '0;
            wr_poison_o <= 1'b0;
            exc_valid_o <= 1'b0;
            exc_cause_o <= CAUSE_NONE;
            exc_reg_o   <= '0;
        end else begin
            wr_en_o     <= verdict.wr_en;
            wr_idx_o    <= ret_dst;
            wr_poison_o <= verdict.wr_poison;
            exc_valid_o <= verdict.raise;
            exc_cause_o <= verdict.cause;
            exc_reg_o   <= verdict.raise ? fault_idx : '0;
        end
    end

endmodule

// File: rtl/poison_tracker_chk.sv
module poison_tracker_chk #(
    parameter int NUM_REGS = 32,
    parameter int IDX_W    = $clog2(NUM_REGS)
) (
    input logic                clk,
    input logic                rst,
    input logic                ret_valid,
    input logic                ret_spec,
    input logic                ret_src_a_en,
    input logic [IDX_W-1:0]    ret_src_a,
    input logic                ret_fault,
    input logic                ret_fault_term,
    input logic                ret_dst_en,
    input logic                wr_en_o,
    input logic [IDX_W-1:0]    wr_idx_o,
    input logic                wr_poison_o,
    input logic                exc_valid_o,
    input logic [1:0]          exc_cause_o,
    input logic [NUM_REGS-1:0] poison_vec
);

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (poison_vec == '0) && !exc_valid_o && !wr_en_o);

    // R2
    spec_term_poisons_chk: assert property (@(posedge clk) disable iff (rst)
        (ret_valid && ret_spec && ret_fault && ret_fault_term && ret_dst_en)
        |=> (wr_en_o && wr_poison_o && !exc_valid_o));

    // R3
    consume_raises_chk: assert property (@(posedge clk) disable iff (rst)
        (ret_valid && !ret_spec && ret_src_a_en && poison_vec[ret_src_a])
        |=> (exc_valid_o && exc_cause_o == 2'd3 && !wr_en_o));

    // R4
    resumable_now_chk: assert property (@(posedge clk) disable iff (rst)
        (ret_valid && ret_spec && ret_fault && !ret_fault_term)
        |=> (exc_valid_o && exc_cause_o == 2'd1 && !wr_en_o));

    // R6
    write_lands_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |-> (poison_vec[wr_idx_o] == wr_poison_o));

    // R8
    exc_follows_retire_chk: assert property (@(posedge clk) disable iff (rst)
        exc_valid_o |-> $past(ret_valid));

    // R7
    write_or_trap_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_en_o && exc_valid_o));

endmodule

bind poison_tracker poison_tracker_chk #(
    .NUM_REGS (NUM_REGS),
    .IDX_W    (IDX_W)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .ret_valid      (ret_valid),
    .ret_spec       (ret_spec),
    .ret_src_a_en   (ret_src_a_en),
    .ret_src_a      (ret_src_a),
    .ret_fault      (ret_fault),
    .ret_fault_term (ret_fault_term),
    .ret_dst_en     (ret_dst_en),
    .wr_en_o        (wr_en_o),
    .wr_idx_o       (wr_idx_o),
    .wr_poison_o    (wr_poison_o),
    .exc_valid_o    (exc_valid_o),
    .exc_cause_o    (exc_cause_o),
    .poison_vec     (poison_vec)
);

// File: tb/poison_tracker_bench.sv
module poison_tracker_bench;

    localparam int IDX_W = 5;

    logic             clk = 1'b0;
    logic             rst;
    logic             ret_valid, ret_spec, ret_src_a_en, ret_src_b_en;
    logic [IDX_W-1:0] ret_src_a, ret_src_b, ret_dst;
    logic             ret_dst_en, ret_fault, ret_fault_term;
    logic             wr_en_o, wr_poison_o, exc_valid_o;
    logic [IDX_W-1:0] wr_idx_o, exc_reg_o;
    logic [1:0]       exc_cause_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    poison_tracker u_poison_tracker (
        .clk, .rst, .ret_valid, .ret_spec, .ret_src_a_en, .ret_src_a,
        .ret_src_b_en, .ret_src_b, .ret_dst_en, .ret_dst, .ret_fault,
        .ret_fault_term, .wr_en_o, .wr_idx_o, .wr_poison_o,
        .exc_valid_o, .exc_cause_o, .exc_reg_o
    );

    task automatic idle_inputs();
        ret_valid = 0; ret_spec = 0; ret_src_a_en = 0; ret_src_a = '0;
        ret_src_b_en = 0; ret_src_b = '0; ret_dst_en = 0; ret_dst = '0;
        ret_fault = 0; ret_fault_term = 0;
    endtask

    // Compare all outputs; idx fields only matter when their enable is expected.
    task automatic expect_out(string req, logic e_wr, logic [IDX_W-1:0] e_widx,
                              logic e_wp, logic e_exc, logic [1:0] e_cause,
                              logic [IDX_W-1:0] e_reg);
        logic ok;
        ok = (wr_en_o == e_wr) && (exc_valid_o == e_exc) && (exc_cause_o == e_cause);
        if (e_wr)  ok = ok && (wr_idx_o == e_widx) && (wr_poison_o == e_wp);
        if (e_exc) ok = ok && (exc_reg_o == e_reg);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual wr=%0b idx=%0d p=%0b exc=%0b cause=%0d reg=%0d expected wr=%0b idx=%0d p=%0b exc=%0b cause=%0d reg=%0d",
                     req, wr_en_o, wr_idx_o, wr_poison_o, exc_valid_o, exc_cause_o, exc_reg_o,
                     e_wr, e_widx, e_wp, e_exc, e_cause, e_reg);
        end
    endtask

    // Drive one retire record; outputs are sampled 1 ns after the next rising edge.
    task automatic issue(logic v, logic spec, logic a_en, logic [IDX_W-1:0] a,
                         logic b_en, logic [IDX_W-1:0] b, logic d_en,
                         logic [IDX_W-1:0] d, logic f, logic t);
        @(negedge clk);
        ret_valid = v; ret_spec = spec; ret_src_a_en = a_en; ret_src_a = a;
        ret_src_b_en = b_en; ret_src_b = b; ret_dst_en = d_en; ret_dst = d;
        ret_fault = f; ret_fault_term = t;
        @(posedge clk);
        #1;
        idle_inputs();
    endtask

    // Non-speculative read of one register reveals its poison flag.
    task automatic probe(string req, logic [IDX_W-1:0] r, logic poisoned);
        issue(1, 0, 1, r, 0, '0, 0, '0, 0, 0);
        if (poisoned) expect_out(req, 0, '0, 0, 1, 2'd3, r);
        else          expect_out(req, 0, '0, 0, 0, 2'd0, '0);
    endtask

    task automatic t_reset();
        rst = 1; idle_inputs();
        repeat (3) @(posedge clk);
        #1;
        expect_out("R1 outputs", 0, '0, 0, 0, 2'd0, '0);
        @(negedge clk); rst = 0;
        probe("R1 reg0", 5'd0, 0);
        probe("R1 reg13", 5'd13, 0);
        probe("R1 reg31", 5'd31, 0);
    endtask

    task automatic t_spec_term();
        issue(1, 1, 0, '0, 0, '0, 1, 5'd7, 1, 1);
        expect_out("R2", 1, 5'd7, 1, 0, 2'd0, '0);
        probe("R2/R3 reg7", 5'd7, 1);
        @(posedge clk); #1;
        expect_out("R8 drop", 0, '0, 0, 0, 2'd0, '0);
        probe("R3 reg7 still", 5'd7, 1);
    endtask

    task automatic t_propagate();
        issue(1, 1, 0, '0, 1, 5'd7, 1, 5'd9, 0, 0);
        expect_out("R5", 1, 5'd9, 1, 0, 2'd0, '0);
        probe("R5 reg9", 5'd9, 1);
    endtask

    task automatic t_order();
        issue(1, 0, 1, 5'd9, 1, 5'd7, 1, 5'd2, 0, 0);
        expect_out("R3 a first", 0, '0, 0, 1, 2'd3, 5'd9);
        issue(1, 0, 1, 5'd3, 1, 5'd7, 1, 5'd2, 0, 0);
        expect_out("R3 b", 0, '0, 0, 1, 2'd3, 5'd7);
        probe("R3 no write reg2", 5'd2, 0);
    endtask

    task automatic t_ignore();
        issue(1, 0, 0, 5'd7, 0, 5'd9, 1, 5'd4, 0, 0);
        expect_out("R10", 1, 5'd4, 0, 0, 2'd0, '0);
        issue(0, 1, 0, '0, 0, '0, 1, 5'd20, 1, 1);
        expect_out("R11", 0, '0, 0, 0, 2'd0, '0);
        probe("R11 reg20", 5'd20, 0);
    endtask

    task automatic t_clear();
        issue(1, 0, 0, '0, 0, '0, 1, 5'd7, 0, 0);
        expect_out("R6 nonspec", 1, 5'd7, 0, 0, 2'd0, '0);
        probe("R6 reg7", 5'd7, 0);
        issue(1, 1, 1, 5'd1, 0, '0, 1, 5'd9, 0, 0);
        expect_out("R6 spec", 1, 5'd9, 0, 0, 2'd0, '0);
        probe("R6 reg9", 5'd9, 0);
    endtask

    task automatic t_resume();
        issue(1, 1, 0, '0, 0, '0, 1, 5'd4, 1, 1);
        expect_out("R2 reg4", 1, 5'd4, 1, 0, 2'd0, '0);
        issue(1, 1, 0, '0, 0, '0, 1, 5'd4, 1, 0);
        expect_out("R4 spec", 0, '0, 0, 1, 2'd1, 5'd4);
        probe("R4 flag kept", 5'd4, 1);
        issue(1, 0, 0, '0, 0, '0, 1, 5'd11, 1, 0);
        expect_out("R4 nonspec", 0, '0, 0, 1, 2'd1, 5'd11);
        issue(1, 0, 1, 5'd4, 0, '0, 1, 5'd12, 1, 0);
        expect_out("R9", 0, '0, 0, 1, 2'd3, 5'd4);
    endtask

    task automatic t_own_term();
        issue(1, 0, 0, '0, 0, '0, 1, 5'd12, 1, 1);
        expect_out("R7", 0, '0, 0, 1, 2'd2, 5'd12);
        @(posedge clk); #1;
        expect_out("R8 one cycle", 0, '0, 0, 0, 2'd0, '0);
        probe("R7 reg12", 5'd12, 0);
    endtask

    initial begin
        t_reset();
        t_spec_term();
        t_propagate();
        t_order();
        t_ignore();
        t_clear();
        t_resume();
        t_own_term();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog: actual hung expected done");
            end
        join_any
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule